// File: doc/BRIEF.md
# Speculative Load-Miss Fence Controller

This block holds back the write-back of speculative loads that missed in the first-level cache. It keeps one fence flag for each load-queue slot. Response packets for a load arrive on a response port. When the last packet of an access has arrived, the block decides from the packets' attributes whether the load must be fenced. A load that is written back while its flag is set goes to the instruction queue's deferred list, marked as waiting only for the fence. It is not marked executed and it does not go to commit. A load whose flag is clear takes the normal path: it is marked executed and then sent to commit.

A visibility-update process clears a slot's flag when it marks that load ready to expose. If the load is parked in the deferred list at that moment, the block pulses a re-issue request carrying the slot index. A squash of a slot clears its flag, its parked state and any packets gathered so far for an access in flight.

When several events name the same slot in one cycle, squash wins over expose, and expose wins over a response that would set the flag. Write-back decisions use the flag value held before the current cycle's updates.

Top module: `lfc_top`

## Requirements
- R1: After a synchronous active-low reset, every bit of fence_flags is 0 and defer_valid, commit_valid and reissue_valid are 0.
- R2: A response with resp_last=1 sets the slot's flag (fence_flags bit = slot index) at that clock edge when some packet of the access had resp_spec=1, resp_read=1 and resp_l1hit=0.
- R3: A response with resp_last=0 does not change the flag. A qualifying packet of a split access still sets the flag when a later, non-qualifying last packet arrives.
- R4: A completed access in which no packet qualifies leaves the flag at 0.
- R5: A write-back (wb_valid) of a slot whose flag is 1 gives defer_valid=1 with defer_idx equal to the slot one cycle later, with commit_valid=0, and parks the slot.
- R6: A write-back of a slot whose flag is 0 gives commit_valid=1 with commit_idx equal to the slot one cycle later, with defer_valid=0.
- R7: expose_valid clears the slot's flag. If the slot is parked, reissue_valid=1 with reissue_idx equal to the slot one cycle later, and the slot is unparked. If the slot is not parked, no re-issue is raised.
- R8: squash_valid clears the slot's flag, its parked state and its gathered packet state. A later expose of that slot raises no re-issue.
- R9: A squash of a slot in the same cycle as a response, write-back or expose of that slot wins: the flag ends at 0 and no defer, commit or re-issue is produced for it.
- R10: defer_valid and commit_valid are never 1 together, and each pulse lasts one cycle for a single write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| resp_valid | input | 1 | A response packet arrives |
| resp_idx | input | IDX_W | Load slot of the packet |
| resp_spec | input | 1 | Packet was a speculative access |
| resp_read | input | 1 | Packet is a read |
| resp_l1hit | input | 1 | Packet hit in the first-level cache |
| resp_last | input | 1 | Last packet of the access |
| wb_valid | input | 1 | Write-back attempt for a load |
| wb_idx | input | IDX_W | Slot being written back |
| expose_valid | input | 1 | Load marked ready to expose |
| expose_idx | input | IDX_W | Slot marked ready |
| squash_valid | input | 1 | Load squashed |
| squash_idx | input | IDX_W | Slot squashed |
| defer_valid | output | 1 | Park the load in the deferred list, waiting only for the fence |
| defer_idx | output | IDX_W | Slot to park |
| commit_valid | output | 1 | Load is marked executed and sent to commit |
| commit_idx | output | IDX_W | Slot sent to commit |
| reissue_valid | output | 1 | Fence cleared on a parked load |
| reissue_idx | output | IDX_W | Slot to re-issue |
| fence_flags | output | NUM_LOADS | Current fence flag of each slot |

## Verification
The assertions check on every cycle that a flag rises only after a last packet for that slot, that expose and squash leave the slot clear, and that a slot is parked only when it was written back with its flag set. They also check that defer and commit are exclusive, that commit never follows a fenced write-back, and that at most one slot asks for re-issue. The bench scenarios show the decision table over all attribute combinations, the gathering of split packets, and the re-issue after a parked load is exposed. They also show that re-issue stays quiet for loads that were never parked or were squashed, and that squash wins when it collides with other events on the same slot.

// File: rtl/lfc_pkg.sv
// Shared types for the load-miss fence controller.
// Assumes response attributes arrive together with the packet's valid strobe.
package lfc_pkg;

    typedef struct packed {
        logic spec;
        logic rd;
        logic l1_hit;
        logic last;
    } resp_attr_t;

    // A packet forces a fence when it is a speculative read that missed the L1.
    function automatic logic must_hold(resp_attr_t a);
        return a.spec & a.rd & ~a.l1_hit;
    endfunction

endpackage

// File: rtl/lfc_slot.sv
// One load-slot tracker: gathers the packets of an access, holds the fence
// flag and the parked state, and raises a re-issue request when the fence is
// lifted on a parked load. Assumes the hit strobes are decoded for this slot.
// Priority on this slot: squash, then expose, then response.
module lfc_slot (
    input  logic clk,
    input  logic rst_n,
    input  logic resp_hit,
    input  logic resp_hold,
    input  logic resp_last,
    input  logic expose_hit,
    input  logic squash_hit,
    input  logic wb_hit,
    output logic fence_o,
    output logic parked_o,
    output logic reissue_o
);

    logic acc_q;
    logic fence_q;
    logic parked_q;
    logic defer_now;

    assign defer_now = wb_hit & fence_q & ~squash_hit;
    assign reissue_o = expose_hit & ~squash_hit & (parked_q | defer_now);
    assign fence_o   = fence_q;
    assign parked_o  = parked_q;

    // Gather the hold condition over the packets of a split access.
    always_ff @(posedge clk) begin
        if (!rst_n || squash_hit) begin
            acc_q <= 1'b0;
        end else if (resp_hit) begin
            acc_q <= resp_last ? 1'b0 : (acc_q | resp_hold);
        end
    end

    // Fence flag: set when the access completes, cleared on expose or squash.
    always_ff @(posedge clk) begin
        if (!rst_n || squash_hit || expose_hit) begin
            fence_q <= 1'b0;
        end else if (resp_hit && resp_last && (acc_q || resp_hold)) begin
            fence_q <= 1'b1;
        end
    end

    // Parked state: set by a fenced write-back, cleared when re-issued or squashed.
    always_ff @(posedge clk) begin
        if (!rst_n || squash_hit || expose_hit) begin
            parked_q <= 1'b0;
        end else if (defer_now) begin
            parked_q <= 1'b1;
        end
    end

    p_set_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fence_q) |-> $past(resp_hit && resp_last));

    p_expose_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        expose_hit |=> !fence_q && !parked_q);

    p_squash_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        squash_hit |=> !fence_q && !parked_q);

    p_park_needs_fence_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(parked_q) |-> $past(wb_hit && fence_q));

endmodule

// File: rtl/lfc_router.sv
// Write-back router: sends a written-back load either to the deferred list
// (flag set) or to commit (flag clear), and encodes the re-issue request.
// Assumes at most one expose per cycle. All outputs are registered.
module lfc_router #(
    parameter  int NUM_LOADS = 8,
    localparam int IDX_W     = (NUM_LOADS > 1) ? $clog2(NUM_LOADS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wb_valid,
    input  logic [IDX_W-1:0]     wb_idx,
    input  logic                 squash_valid,
    input  logic [IDX_W-1:0]     squash_idx,
    input  logic [NUM_LOADS-1:0] fence_vec,
    input  logic [NUM_LOADS-1:0] reissue_req,
    output logic                 defer_valid,
    output logic [IDX_W-1:0]     defer_idx,
    output logic                 commit_valid,
    output logic [IDX_W-1:0]     commit_idx,
    output logic                 reissue_valid,
    output logic [IDX_W-1:0]     reissue_idx
);

    logic             wb_live;
    logic             wb_fenced;
    logic [IDX_W-1:0] req_enc;

    assign wb_live   = wb_valid && !(squash_valid && squash_idx == wb_idx);
    assign wb_fenced = fence_vec[wb_idx];

    // Encode the single re-issue request into a slot index.
    always_comb begin
        req_enc = '0;
        for (int i = 0; i < NUM_LOADS; i++) begin
            if (reissue_req[i]) req_enc = IDX_W'(i);
        end
    end

    // Register the routing decision and the re-issue pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            defer_valid   <= 1'b0;
            defer_idx     <= '0;
            commit_valid  <= 1'b0;
            commit_idx    <= '0;
            reissue_valid <= 1'b0;
            reissue_idx   <= '0;
        end else begin
            defer_valid   <= wb_live && wb_fenced;
            defer_idx     <= wb_idx;
            commit_valid  <= wb_live && !wb_fenced;
            commit_idx    <= wb_idx;
            reissue_valid <= |reissue_req;
            reissue_idx   <= req_enc;
        end
    end

    p_defer_commit_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(defer_valid && commit_valid));

    p_commit_unfenced_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid |-> $past(wb_valid) && !$past(fence_vec[wb_idx]));

    p_single_reissue_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reissue_req));

endmodule

// File: rtl/lfc_top.sv
// Speculative load-miss fence controller top: decodes the slot strobes,
// instantiates one tracker per load slot and the write-back router.
// Assumes at most one event of each kind per cycle.
module lfc_top #(
    parameter  int NUM_LOADS = 8,
    localparam int IDX_W     = (NUM_LOADS > 1) ? $clog2(NUM_LOADS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 resp_valid,
    input  logic [IDX_W-1:0]     resp_idx,
    input  logic                 resp_spec,
    input  logic                 resp_read,
    input  logic                 resp_l1hit,
    input  logic                 resp_last,
    input  logic                 wb_valid,
    input  logic [IDX_W-1:0]     wb_idx,
    input  logic                 expose_valid,
    input  logic [IDX_W-1:0]     expose_idx,
    input  logic                 squash_valid,
    input  logic [IDX_W-1:0]     squash_idx,
    output logic                 defer_valid,
    output logic [IDX_W-1:0]     defer_idx,
    output logic                 commit_valid,
    output logic [IDX_W-1:0]     commit_idx,
    output logic                 reissue_valid,
    output logic [IDX_W-1:0]     reissue_idx,
    output logic [NUM_LOADS-1:0] fence_flags
);
    import lfc_pkg::*;

    resp_attr_t           attr;
    logic                 hold;
    logic [NUM_LOADS-1:0] parked;
    logic [NUM_LOADS-1:0] reissue_req;

    assign attr = '{spec: resp_spec, rd: resp_read, l1_hit: resp_l1hit, last: resp_last};
    assign hold = must_hold(attr);

    for (genvar i = 0; i < NUM_LOADS; i++) begin : g_slot
        lfc_slot u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .resp_hit   (resp_valid   && resp_idx   == IDX_W'(i)),
            .resp_hold  (hold),
            .resp_last  (attr.last),
            .expose_hit (expose_valid && expose_idx == IDX_W'(i)),
            .squash_hit (squash_valid && squash_idx == IDX_W'(i)),
            .wb_hit     (wb_valid     && wb_idx     == IDX_W'(i)),
            .fence_o    (fence_flags[i]),
            .parked_o   (parked[i]),
            .reissue_o  (reissue_req[i])
        );
    end

    lfc_router #(.NUM_LOADS(NUM_LOADS)) u_router (
        .clk           (clk),
        .rst_n         (rst_n),
        .wb_valid      (wb_valid),
        .wb_idx        (wb_idx),
        .squash_valid  (squash_valid),
        .squash_idx    (squash_idx),
        .fence_vec     (fence_flags),
        .reissue_req   (reissue_req),
        .defer_valid   (defer_valid),
        .defer_idx     (defer_idx),
        .commit_valid  (commit_valid),
        .commit_idx    (commit_idx),
        .reissue_valid (reissue_valid),
        .reissue_idx   (reissue_idx)
    );

    p_reissue_only_parked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reissue_valid |-> $past(expose_valid) && !$past(squash_valid && squash_idx == expose_idx));

    p_parked_is_unique_r5: assert property (@(posedge clk) disable iff (!rst_n)
        defer_valid |-> !commit_valid && $past(wb_valid));

endmodule

// File: tb/lfc_top_bench.sv
`timescale 1ns/1ps
// Bench for the fence controller: a table over all response attribute
// combinations, then directed tests for reset, split access, expose,
// squash and same-cycle collisions.
module lfc_top_bench;

    localparam int N  = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          resp_valid = 0, resp_spec = 0, resp_read = 0, resp_l1hit = 0, resp_last = 0;
    logic [IW-1:0] resp_idx = '0, wb_idx = '0, expose_idx = '0, squash_idx = '0;
    logic          wb_valid = 0, expose_valid = 0, squash_valid = 0;
    logic          defer_valid, commit_valid, reissue_valid;
    logic [IW-1:0] defer_idx, commit_idx, reissue_idx;
    logic [N-1:0]  fence_flags;

    int total = 0;
    int fails = 0;
    int cycles = 0;

    // Row k = {spec, read, l1hit}; bits [3:1] carry those, bit 0 the expected hold.
    localparam logic [3:0] VEC [0:7] = '{
        4'b0000, 4'b0010, 4'b0100, 4'b0110,
        4'b1000, 4'b1010, 4'b1101, 4'b1110
    };

    lfc_top #(.NUM_LOADS(N)) u_lfc_top (
        .clk(clk), .rst_n(rst_n),
        .resp_valid(resp_valid), .resp_idx(resp_idx), .resp_spec(resp_spec),
        .resp_read(resp_read), .resp_l1hit(resp_l1hit), .resp_last(resp_last),
        .wb_valid(wb_valid), .wb_idx(wb_idx),
        .expose_valid(expose_valid), .expose_idx(expose_idx),
        .squash_valid(squash_valid), .squash_idx(squash_idx),
        .defer_valid(defer_valid), .defer_idx(defer_idx),
        .commit_valid(commit_valid), .commit_idx(commit_idx),
        .reissue_valid(reissue_valid), .reissue_idx(reissue_idx),
        .fence_flags(fence_flags)
    );

    always #10 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            total++;
            fails++;
            $display("FAIL watchdog actual %0d expected %0d", cycles, 20000);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Let one clock edge take the driven inputs, then clear them at the negedge.
    task automatic step();
        @(negedge clk);
        resp_valid = 0; wb_valid = 0; expose_valid = 0; squash_valid = 0;
    endtask

    task automatic resp(input int idx, input logic s, input logic r, input logic h, input logic l);
        resp_valid = 1; resp_idx = IW'(idx);
        resp_spec = s; resp_read = r; resp_l1hit = h; resp_last = l;
    endtask

    task automatic do_reset();
        rst_n = 0;
        step();
        step();
        rst_n = 1;
    endtask

    initial begin
        do_reset();
        // R1: reset state
        chk("R1 flags", int'(fence_flags), 0);
        chk("R1 outputs", int'({defer_valid, commit_valid, reissue_valid}), 0);

        // Table over every attribute combination, one slot each.
        for (int k = 0; k < 8; k++) begin
            resp(k, VEC[k][3], VEC[k][2], VEC[k][1], 1'b1);
            step();
            chk(VEC[k][0] ? "R2 flag set" : "R4 flag clear", int'(fence_flags[k]), int'(VEC[k][0]));
            wb_valid = 1; wb_idx = IW'(k);
            step();
            if (VEC[k][0]) begin
                chk("R5 defer", int'({defer_valid, commit_valid}), 2);
                chk("R5 defer_idx", int'(defer_idx), k);
            end else begin
                chk("R6 commit", int'({defer_valid, commit_valid}), 1);
                chk("R6 commit_idx", int'(commit_idx), k);
            end
            step();
            chk("R10 single pulse", int'({defer_valid, commit_valid}), 0);
        end

        // R7: expose parked slot 6 raises re-issue and clears the flag.
        expose_valid = 1; expose_idx = 3'd6;
        step();
        chk("R7 reissue", int'(reissue_valid), 1);
        chk("R7 reissue_idx", int'(reissue_idx), 6);
        chk("R7 flag clear", int'(fence_flags[6]), 0);
        wb_valid = 1; wb_idx = 3'd6;
        step();
        chk("R6 commit after expose", int'(commit_valid), 1);

        // R7: expose of a slot that was never parked stays quiet.
        expose_valid = 1; expose_idx = 3'd1;
        step();
        chk("R7 no reissue unparked", int'(reissue_valid), 0);

        // R3: split access gathering.
        resp(2, 1, 1, 0, 0);
        step();
        chk("R3 nonlast no effect", int'(fence_flags[2]), 0);
        resp(2, 0, 1, 1, 1);
        step();
        chk("R3 split sets flag", int'(fence_flags[2]), 1);

        // R8: squash a parked slot; a later expose raises nothing.
        resp(3, 1, 1, 0, 1);
        step();
        wb_valid = 1; wb_idx = 3'd3;
        step();
        chk("R5 defer slot3", int'(defer_valid), 1);
        squash_valid = 1; squash_idx = 3'd3;
        step();
        chk("R8 squash clears flag", int'(fence_flags[3]), 0);
        expose_valid = 1; expose_idx = 3'd3;
        step();
        chk("R8 no reissue after squash", int'(reissue_valid), 0);

        // R8: squash drops gathered packets of an access in flight.
        resp(7, 1, 1, 0, 0);
        step();
        squash_valid = 1; squash_idx = 3'd7;
        step();
        resp(7, 0, 0, 1, 1);
        step();
        chk("R8 gathered state dropped", int'(fence_flags[7]), 0);

        // R9: squash and write-back of a fenced slot in one cycle.
        resp(5, 1, 1, 0, 1);
        step();
        wb_valid = 1; wb_idx = 3'd5; squash_valid = 1; squash_idx = 3'd5;
        step();
        chk("R9 no defer or commit", int'({defer_valid, commit_valid}), 0);
        chk("R9 flag clear", int'(fence_flags[5]), 0);

        // R9: squash beats a setting response in one cycle.
        resp(4, 1, 1, 0, 1); squash_valid = 1; squash_idx = 3'd4;
        step();
        chk("R9 response loses", int'(fence_flags[4]), 0);

        // R1: reset clears outstanding flags.
        do_reset();
        chk("R1 flags after reset", int'(fence_flags), 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule